// File: doc/BRIEF.md
# Configuration Access Width Adapter

This block sits between a configuration-space requester and a plain 32-bit memory-mapped backend. A request names a bus number, a device/function, a register offset, a size (byte, halfword or word) and, for writes, the data. The block screens the request and routes it to one of two local root-port register windows or to the downstream configuration window. It then does the access as one or two aligned 32-bit backend operations.

Reads fetch the aligned word and return the addressed lane, shifted down to bit 0 and masked to the requested width. Byte and halfword writes are done as a read of the aligned word, a merge of the new lane into it, and a write-back. Word writes go straight to the backend. A request that fails the screen completes without touching the backend. A rejected read returns all ones in the requested bytes, and a rejected write is dropped. The block handles one request at a time.

The controller is a four-state machine:
- `ST_IDLE` waits for a request. On acceptance it moves to `ST_REPLY` if the request is rejected, to `ST_STORE` for a word write, and to `ST_FETCH` otherwise.
- `ST_FETCH` holds a backend read until `bk_ready`. It then moves to `ST_STORE` for a sub-word write, or to `ST_REPLY` for a read.
- `ST_STORE` holds a backend write until `bk_ready`, then moves to `ST_REPLY`.
- `ST_REPLY` drives the one-cycle response and returns to `ST_IDLE`.

Top module: `cfg_width_adapter`

## Requirements
- R1: A request is rejected when `dev_present` is 0, or when `req_off` is greater than 4096. A rejected read responds with 0xFF in each requested byte: 0x000000FF for a byte, 0x0000FFFF for a halfword, 0xFFFFFFFF for a word. A rejected write responds with data 0. Neither kind makes any backend access.
- R2: A request on a root-port bus (bus 0 for port 0, bus 16 for port 1) with a nonzero `req_devfn` is rejected. With `req_devfn` 0, the access goes to address 0x10000000 (port 0) or 0x10002000 (port 1), plus `req_off` with bits [1:0] cleared.
- R3: On bus 1, a request whose slot field (`req_devfn[7:3]`) is nonzero is rejected. Any other non-root-port request goes to address 0x80000000 + {bus, devfn, offset with bits [1:0] cleared}, taken as a 29-bit value.
- R4: Every backend access uses a word-aligned address, so `bk_addr[1:0]` is always 0.
- R5: A byte read (size code 1) returns the fetched word shifted right by 16 if offset bit 1 is set, then by 8 if offset bit 0 is set, masked to 8 bits.
- R6: A halfword read (size code 2) returns the fetched word shifted right by 16 if offset bit 1 is set, masked to 16 bits. Offset bit 0 is ignored. A word read returns the fetched word unchanged, and any size code other than 1 or 2 is treated as a word.
- R7: A byte or halfword write does exactly one backend read and then one backend write to the same aligned address. The written word is the fetched word with the lane at bit (offset[1:0]×8) replaced by the low 8 or 16 bits of the write data. Lane bits that fall above bit 31 are dropped, and write-data bits above the lane width are ignored.
- R8: A word write does exactly one backend write with the request data unchanged, and no backend read.
- R9: `busy` is high from the cycle after acceptance until the response has been given. Each accepted request produces exactly one single-cycle `rsp_valid` pulse. A request presented while `busy` is high, including in the response cycle, is ignored.
- R10: Once `bk_valid` is raised, address, direction and write data stay stable until `bk_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_present | input | 1 | A device is attached; 0 rejects every request |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device/function, slot in bits [7:3] |
| req_off | input | 13 | Register byte offset |
| req_size | input | 3 | Size code: 1 byte, 2 halfword, other values word |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, valid with `rsp_valid` |
| bk_valid | output | 1 | Backend access request |
| bk_write | output | 1 | Backend direction, 1 = write |
| bk_addr | output | 32 | Backend word address |
| bk_wdata | output | 32 | Backend write data |
| bk_ready | input | 1 | Backend completion; read data valid in the same cycle |
| bk_rdata | input | 32 | Backend read data |

## Verification
Two things can land in the same cycle: a new request from the requester and the completion of the current one, when `rsp_valid` is high in `ST_REPLY` while `busy` is still high. The bench provokes this by holding a poison word write on the request port for the whole busy window, including the response cycle. It then checks three things: the target word of the poison write is unchanged, the backend read and write counts for the request in flight match its expected counts, and no extra response appears. Backend latency is varied from zero to two cycles, so `bk_ready` arrives both in the first cycle of a backend access and after a hold.

// File: rtl/cfg_wa_pkg.sv
package cfg_wa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_REPLY
    } cfg_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE,
        SZ_HALF,
        SZ_WORD
    } cfg_size_e;

    localparam int WORD_W = 32;

    function automatic cfg_size_e decode_size(input logic [2:0] code);
        unique case (code)
            3'd1:    return SZ_BYTE;
            3'd2:    return SZ_HALF;
            default: return SZ_WORD;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] lane_mask(input cfg_size_e sz);
        unique case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_wa_route.sv
module cfg_wa_route
    import cfg_wa_pkg::*;
#(
    parameter int                BUS_W     = 8,
    parameter int                DEVFN_W   = 8,
    parameter int                OFF_W     = 13,
    parameter int                ADDR_W    = 32,
    parameter int                OFF_LIMIT = 4096,
    parameter int                SLOT_LSB  = 3,
    parameter logic [BUS_W-1:0]  RP_BUS0   = 8'd0,
    parameter logic [BUS_W-1:0]  RP_BUS1   = 8'd16,
    parameter logic [BUS_W-1:0]  LEAF_BUS  = 8'd1,
    parameter logic [ADDR_W-1:0] RP_BASE0  = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] RP_BASE1  = 32'h1000_2000,
    parameter logic [ADDR_W-1:0] DN_BASE   = 32'h8000_0000
) (
    input  logic               present,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [OFF_W-1:0]   off,
    output logic               reject,
    output logic [ADDR_W-1:0]  addr
);
    localparam int NRP = 2;
    localparam logic [BUS_W-1:0]  RP_BUS  [NRP] = '{RP_BUS0, RP_BUS1};
    localparam logic [ADDR_W-1:0] RP_BASE [NRP] = '{RP_BASE0, RP_BASE1};

    logic [OFF_W-1:0]  off_al;
    logic [NRP-1:0]    rp_hit;
    logic [ADDR_W-1:0] rp_addr [NRP];
    logic [ADDR_W-1:0] dn_addr;

    assign off_al  = {off[OFF_W-1:2], 2'b00};
    assign dn_addr = DN_BASE + ADDR_W'({bus, devfn, off_al});

    for (genvar g = 0; g < NRP; g++) begin : g_port
        assign rp_hit[g]  = (bus == RP_BUS[g]);
        assign rp_addr[g] = RP_BASE[g] + ADDR_W'(off_al);
    end

    always_comb begin
        reject = 1'b0;
        addr   = dn_addr;
        if (!present || off > OFF_W'(OFF_LIMIT)) begin
            reject = 1'b1;
        end else if (|rp_hit) begin
            reject = (devfn != '0);
            for (int i = 0; i < NRP; i++) begin
                if (rp_hit[i]) addr = rp_addr[i];
            end
        end else if (bus == LEAF_BUS && devfn[DEVFN_W-1:SLOT_LSB] != '0) begin
            reject = 1'b1;
        end
    end

endmodule

// File: rtl/cfg_wa_lane.sv
module cfg_wa_lane
    import cfg_wa_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        lane,
    input  cfg_size_e         size,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_val,
    output logic [WORD_W-1:0] merged
);
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] mask;
    logic [4:0]        bitpos;

    assign mask   = lane_mask(size);
    assign bitpos = {lane, 3'b000};

    always_comb begin
        shifted = word;
        if (size != SZ_WORD && lane[1]) shifted = shifted >> 16;
        if (size == SZ_BYTE && lane[0]) shifted = shifted >> 8;
        rd_val = shifted & mask;
    end

    assign merged = (word & ~(mask << bitpos)) | ((wdata & mask) << bitpos);

endmodule

// File: rtl/cfg_width_adapter.sv
module cfg_width_adapter
    import cfg_wa_pkg::*;
#(
    parameter int                BUS_W     = 8,
    parameter int                DEVFN_W   = 8,
    parameter int                OFF_W     = 13,
    parameter int                ADDR_W    = 32,
    parameter int                OFF_LIMIT = 4096,
    parameter logic [BUS_W-1:0]  RP_BUS0   = 8'd0,
    parameter logic [BUS_W-1:0]  RP_BUS1   = 8'd16,
    parameter logic [BUS_W-1:0]  LEAF_BUS  = 8'd1,
    parameter logic [ADDR_W-1:0] RP_BASE0  = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] RP_BASE1  = 32'h1000_2000,
    parameter logic [ADDR_W-1:0] DN_BASE   = 32'h8000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dev_present,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [2:0]         req_size,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic               busy,
    output logic               rsp_valid,
    output logic [WORD_W-1:0]  rsp_rdata,
    output logic               bk_valid,
    output logic               bk_write,
    output logic [ADDR_W-1:0]  bk_addr,
    output logic [WORD_W-1:0]  bk_wdata,
    input  logic               bk_ready,
    input  logic [WORD_W-1:0]  bk_rdata
);
    cfg_state_e        state, state_nx;
    cfg_size_e         in_size, r_size;
    logic              r_write;
    logic [1:0]        r_lane;
    logic [WORD_W-1:0] r_wdata, r_word, rsp_data;
    logic [ADDR_W-1:0] r_addr;
    logic              route_reject;
    logic [ADDR_W-1:0] route_addr;
    logic [WORD_W-1:0] lane_rd, lane_merged;

    assign in_size = decode_size(req_size);

    cfg_wa_route #(
        .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W),
        .OFF_LIMIT(OFF_LIMIT), .SLOT_LSB(3),
        .RP_BUS0(RP_BUS0), .RP_BUS1(RP_BUS1), .LEAF_BUS(LEAF_BUS),
        .RP_BASE0(RP_BASE0), .RP_BASE1(RP_BASE1), .DN_BASE(DN_BASE)
    ) u_route (
        .present (dev_present),
        .bus     (req_bus),
        .devfn   (req_devfn),
        .off     (req_off),
        .reject  (route_reject),
        .addr    (route_addr)
    );

    cfg_wa_lane u_lane (
        .word   (bk_rdata),
        .lane   (r_lane),
        .size   (r_size),
        .wdata  (r_wdata),
        .rd_val (lane_rd),
        .merged (lane_merged)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                if (route_reject)                      state_nx = ST_REPLY;
                else if (req_write && in_size == SZ_WORD) state_nx = ST_STORE;
                else                                   state_nx = ST_FETCH;
            end
            ST_FETCH: if (bk_ready) state_nx = r_write ? ST_STORE : ST_REPLY;
            ST_STORE: if (bk_ready) state_nx = ST_REPLY;
            ST_REPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        bk_valid  = (state == ST_FETCH) || (state == ST_STORE);
        bk_write  = (state == ST_STORE);
        bk_addr   = r_addr;
        bk_wdata  = r_word;
        rsp_valid = (state == ST_REPLY);
        rsp_rdata = rsp_data;
    end

    // request capture and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_write  <= 1'b0;
            r_size   <= SZ_WORD;
            r_lane   <= 2'b00;
            r_wdata  <= '0;
            r_word   <= '0;
            r_addr   <= '0;
            rsp_data <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    r_write  <= req_write;
                    r_size   <= in_size;
                    r_lane   <= req_off[1:0];
                    r_wdata  <= req_wdata;
                    r_word   <= req_wdata;
                    r_addr   <= route_addr;
                    rsp_data <= (route_reject && !req_write) ? lane_mask(in_size) : '0;
                end
                ST_FETCH: if (bk_ready) begin
                    if (r_write) r_word   <= lane_merged;
                    else         rsp_data <= lane_rd;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cfg_width_adapter_chk.sv
module cfg_width_adapter_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dev_present,
    input logic              req_valid,
    input logic              busy,
    input logic              rsp_valid,
    input logic              bk_valid,
    input logic              bk_write,
    input logic [ADDR_W-1:0] bk_addr,
    input logic [31:0]       bk_wdata,
    input logic              bk_ready
);
    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bk_valid |-> bk_addr[1:0] == 2'b00);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_valid && !bk_ready) |=> (bk_valid && $stable(bk_addr) &&
                                     $stable(bk_write) && $stable(bk_wdata)));

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !busy);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bk_valid && !rsp_valid));

    p_absent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !dev_present) |=> (rsp_valid && !bk_valid));

endmodule

bind cfg_width_adapter cfg_width_adapter_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_present (dev_present),
    .req_valid   (req_valid),
    .busy        (busy),
    .rsp_valid   (rsp_valid),
    .bk_valid    (bk_valid),
    .bk_write    (bk_write),
    .bk_addr     (bk_addr),
    .bk_wdata    (bk_wdata),
    .bk_ready    (bk_ready)
);

// File: tb/cfg_width_adapter_tb_top.sv
module cfg_width_adapter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_present = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [12:0] req_off = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, rsp_valid, bk_valid, bk_write;
    logic [31:0] rsp_rdata, bk_addr, bk_wdata;
    logic        bk_ready = 1'b0;
    logic [31:0] bk_rdata = '0;

    always #2 clk = ~clk;

    cfg_width_adapter dut_i (
        .clk(clk), .rst_n(rst_n), .dev_present(dev_present),
        .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
        .req_devfn(req_devfn), .req_off(req_off), .req_size(req_size),
        .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .bk_valid(bk_valid), .bk_write(bk_write),
        .bk_addr(bk_addr), .bk_wdata(bk_wdata), .bk_ready(bk_ready),
        .bk_rdata(bk_rdata)
    );

    typedef struct {
        logic [31:0] rdata;
        int          rd0;
        int          wr0;
        int          exp_rd;
        int          exp_wr;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          fails = 0;
    int          rd_count = 0;
    int          wr_count = 0;
    int          rsp_seen = 0;
    int          lat = 0;
    int          wait_cnt = 0;
    logic [31:0] mem [logic [31:0]];

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] dn(input logic [7:0] b, input logic [7:0] df,
                                       input logic [12:0] o);
        return 32'h8000_0000 + {3'b000, b, df, o[12:2], 2'b00};
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] w, input logic [12:0] o,
                                             input logic [2:0] sz);
        if (sz == 3'd1) return (w >> (8 * o[1:0])) & 32'hFF;
        if (sz == 3'd2) return o[1] ? (w >> 16) : (w & 32'hFFFF);
        return w;
    endfunction

    function automatic logic [31:0] exp_merge(input logic [31:0] w, input logic [12:0] o,
                                              input logic [2:0] sz, input logic [31:0] d);
        logic [31:0] r;
        int n;
        r = w;
        n = (sz == 3'd1) ? 1 : 2;
        for (int i = 0; i < 4; i++) begin
            if (i >= o[1:0] && i < o[1:0] + n) r[8*i +: 8] = d[8*(i - o[1:0]) +: 8];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // backend memory model
    initial begin
        forever begin
            @(negedge clk);
            bk_ready = 1'b0;
            if (bk_valid) begin
                if (wait_cnt >= lat) begin
                    bk_ready = 1'b1;
                    wait_cnt = 0;
                    if (bk_write) begin
                        mem[bk_addr] = bk_wdata;
                        wr_count++;
                    end else begin
                        bk_rdata = mem_rd(bk_addr);
                        rd_count++;
                    end
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected response", rsp_rdata, 32'h0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    chk(rsp_rdata == it.rdata, it.tag, rsp_rdata, it.rdata);
                    chk(rd_count - it.rd0 == it.exp_rd, {it.tag, " backend reads"},
                        32'(rd_count - it.rd0), 32'(it.exp_rd));
                    chk(wr_count - it.wr0 == it.exp_wr, {it.tag, " backend writes"},
                        32'(wr_count - it.wr0), 32'(it.exp_wr));
                end
                rsp_seen++;
            end
        end
    end

    task automatic issue(input bit w, input logic [7:0] b, input logic [7:0] df,
                         input logic [12:0] o, input logic [2:0] sz,
                         input logic [31:0] d, input logic [31:0] erd,
                         input int nrd, input int nwr, input string tag,
                         input bit poison);
        exp_t it;
        int target;
        @(negedge clk);
        while (busy) @(negedge clk);
        it.rdata = erd; it.rd0 = rd_count; it.wr0 = wr_count;
        it.exp_rd = nrd; it.exp_wr = nwr; it.tag = tag;
        sb.push_back(it);
        target = rsp_seen + 1;
        req_write = w; req_bus = b; req_devfn = df; req_off = o;
        req_size = sz; req_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) begin
            if (poison) begin
                req_valid = 1'b1; req_write = 1'b1; req_bus = 8'd2;
                req_devfn = 8'h08; req_off = 13'h40; req_size = 3'd4;
                req_wdata = 32'hDEAD_BEEF;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait (rsp_seen >= target);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] a, w0, pw;
        repeat (3) @(negedge clk);
        // reset state (R9)
        chk(!busy && !rsp_valid && !bk_valid, "R9 reset idle",
            {29'd0, busy, rsp_valid, bk_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        a = dn(8'd2, 8'h28, 13'h10);
        mem[a] = 32'hA1B2_C3D4;
        // R3/R6: downstream word read
        issue(0, 8'd2, 8'h28, 13'h10, 3'd4, 0, 32'hA1B2_C3D4, 1, 0, "R3 R6 word read", 0);
        // R5: byte reads in each lane, various latencies (R10)
        for (int i = 0; i < 4; i++) begin
            lat = i % 3;
            issue(0, 8'd2, 8'h28, 13'(16 + i), 3'd1, 0,
                  exp_read(32'hA1B2_C3D4, 13'(16 + i), 3'd1), 1, 0, "R5 R10 byte read", 0);
        end
        // R6: halfword reads, odd offsets
        issue(0, 8'd2, 8'h28, 13'h11, 3'd2, 0, 32'h0000_C3D4, 1, 0, "R6 half read low", 0);
        issue(0, 8'd2, 8'h28, 13'h13, 3'd2, 0, 32'h0000_A1B2, 1, 0, "R6 half read high", 0);
        issue(0, 8'd2, 8'h28, 13'h12, 3'd3, 0, 32'hA1B2_C3D4, 1, 0, "R6 size3 as word", 0);
        lat = 1;
        // R2: root-port windows
        mem[32'h1000_0008] = 32'h1111_2222;
        mem[32'h1000_2008] = 32'h3333_4444;
        issue(0, 8'd0, 8'h00, 13'h0A, 3'd2, 0, 32'h0000_1111, 1, 0, "R2 port0 read", 0);
        issue(0, 8'd16, 8'h00, 13'h09, 3'd1, 0, 32'h0000_0044, 1, 0, "R2 port1 read", 0);
        issue(0, 8'd0, 8'h01, 13'h08, 3'd4, 0, 32'hFFFF_FFFF, 0, 0, "R2 port devfn reject", 0);
        issue(1, 8'd16, 8'h08, 13'h08, 3'd4, 32'h0BAD_0BAD, 0, 0, 0, "R2 port write reject", 0);
        chk(mem_rd(32'h1000_2008) == 32'h3333_4444, "R2 reject write dropped",
            mem_rd(32'h1000_2008), 32'h3333_4444);
        // R3: bus 1 slot filter
        issue(0, 8'd1, 8'h08, 13'h00, 3'd1, 0, 32'h0000_00FF, 0, 0, "R3 bus1 slot1 reject", 0);
        a = dn(8'd1, 8'h03, 13'h04);
        issue(0, 8'd1, 8'h03, 13'h04, 3'd4, 0, mem_rd(a), 1, 0, "R3 bus1 slot0 func3", 0);
        // R1: offset limit and absent device
        a = dn(8'd3, 8'h00, 13'd4096);
        issue(0, 8'd3, 8'h00, 13'd4096, 3'd4, 0, mem_rd(a), 1, 0, "R1 offset 4096 ok", 0);
        issue(0, 8'd3, 8'h00, 13'd4097, 3'd4, 0, 32'hFFFF_FFFF, 0, 0, "R1 offset 4097 reject", 0);
        dev_present = 1'b0;
        issue(0, 8'd2, 8'h28, 13'h10, 3'd2, 0, 32'h0000_FFFF, 0, 0, "R1 absent half read", 0);
        issue(1, 8'd2, 8'h28, 13'h10, 3'd4, 32'h7777_7777, 0, 0, 0, "R1 absent write", 0);
        chk(mem_rd(dn(8'd2, 8'h28, 13'h10)) == 32'hA1B2_C3D4, "R1 absent write dropped",
            mem_rd(dn(8'd2, 8'h28, 13'h10)), 32'hA1B2_C3D4);
        dev_present = 1'b1;
        // R7: sub-word read-modify-write
        a = dn(8'd4, 8'h10, 13'h20);
        mem[a] = 32'h8899_AABB;
        issue(1, 8'd4, 8'h10, 13'h21, 3'd1, 32'hFFFF_FF5C, 0, 1, 1, "R7 byte write", 0);
        w0 = exp_merge(32'h8899_AABB, 13'h21, 3'd1, 32'hFFFF_FF5C);
        chk(mem_rd(a) == w0, "R7 byte merge", mem_rd(a), w0);
        issue(1, 8'd4, 8'h10, 13'h22, 3'd2, 32'hABCD_1234, 0, 1, 1, "R7 half write", 0);
        w0 = exp_merge(w0, 13'h22, 3'd2, 32'hABCD_1234);
        chk(mem_rd(a) == w0, "R7 half merge", mem_rd(a), w0);
        issue(1, 8'd4, 8'h10, 13'h23, 3'd2, 32'h0000_9876, 0, 1, 1, "R7 half write top lane", 0);
        w0 = exp_merge(w0, 13'h23, 3'd2, 32'h0000_9876);
        chk(mem_rd(a) == w0, "R7 half top merge", mem_rd(a), w0);
        // R8: word write straight through, R9 poison during busy
        pw = mem_rd(dn(8'd2, 8'h08, 13'h40));
        lat = 2;
        issue(1, 8'd4, 8'h10, 13'h20, 3'd4, 32'hCAFE_F00D, 0, 0, 1, "R8 R9 word write", 1);
        chk(mem_rd(a) == 32'hCAFE_F00D, "R8 word stored", mem_rd(a), 32'hCAFE_F00D);
        chk(mem_rd(dn(8'd2, 8'h08, 13'h40)) == pw, "R9 poison ignored",
            mem_rd(dn(8'd2, 8'h08, 13'h40)), pw);
        issue(0, 8'd4, 8'h10, 13'h22, 3'd1, 0, 32'h0000_00FE, 1, 0, "R9 poison on read", 1);
        chk(mem_rd(dn(8'd2, 8'h08, 13'h40)) == pw, "R9 poison ignored on read",
            mem_rd(dn(8'd2, 8'h08, 13'h40)), pw);
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R9 response count", 32'(sb.size()), 32'h0);
        finish_up();
    end

endmodule